// File: doc/BRIEF.md
# Last-Branch Record Ring Buffer

This block keeps a short history of taken branches for profiling. Each branch that retires arrives already classified, with its source and destination addresses, a class code, the privilege ring of the target and three flags: mispredicted, inside a transaction, and transaction aborted. When a branch is recorded, the top-of-stack pointer (TOS) steps forward by one slot and the branch is written into the slot that TOS then names. TOS therefore always points at the newest record. The slots form a ring of `DEPTH` entries, and `DEPTH` is a power of two. The i-th newest record is held in slot (TOS − i) mod `DEPTH`.

A 10-bit select register decides which branches are kept. Bits 0 to 8 each discard one group of branches when set. Bit 9 switches the ring into a call-stack mode: calls push a record and returns pop one. Recording needs an enable input. It can also be frozen by a performance-monitor interrupt, and it stays frozen until software clears the freeze. A register port loads or reads any slot, TOS and the select register, so software can save and restore the buffer. A streaming readout walks the records from newest to oldest.

Branch events use a valid/ready handshake. `br_ready` is low in any cycle where a register write is presented, `walk_start` is high, or a readout is in progress. An event moves only in a cycle with both `br_valid` and `br_ready` high. The readout stream holds `rd_valid` and its payload until the consumer raises `rd_ready`.

Top module: `lbr_ring`

## Requirements
- R1: After reset, every stored source and destination field reads zero, TOS reads 0, the select register reads 0 and `frozen` is low.
- R2: A recorded branch in normal mode first sets TOS to (TOS+1) mod `DEPTH`, then writes the slot TOS names. The stored source field is {mispredict at bit 63, in-transaction at bit 62, abort at bit 61, the address sign-extended from bit `VA_W`−1 through bit 60}. The stored destination field is the address sign-extended to 64 bits.
- R3: With select bit 0 set, a branch whose target is ring 0 (`br_ring0`=1) is discarded. With select bit 1 set, a branch whose target is any other ring is discarded.
- R4: Class codes are 0 conditional, 1 relative call, 2 indirect call, 3 near return, 4 indirect jump, 5 relative jump, 6 far branch, and 7 reserved. Select bit (2 + code) discards class code 0–6. Code 7 is always discarded.
- R5: With select bit 9 set, codes 1 and 2 push a record as in R2, and code 3 sets TOS to (TOS−1) mod `DEPTH` without writing any slot, so popping at TOS 0 gives `DEPTH`−1. All other codes leave the buffer alone. Bits 0–8 still discard branches in this mode.
- R6: While `rec_en` is low, no branch changes TOS or any slot.
- R7: When `pmi` is high and `frz_on_pmi` is high outside call-stack mode, a branch in the same cycle is not recorded and `frozen` goes high at the next edge. While `frozen` is high nothing is recorded. `frz_clr` lowers `frozen`, but a new freeze in the same cycle wins.
- R8: With select bit 9 set, `pmi` never raises `frozen`.
- R9: `reg_addr` bits [`IDX_W`+1:`IDX_W`] pick the target: 0 source field, 1 destination field, 2 TOS, 3 select. The low `IDX_W` bits pick the slot. `reg_rdata` shows the addressed value in the same cycle. A write takes effect at the edge. TOS takes the low `IDX_W` bits of the write data and select takes the low 10 bits.
- R10: `br_ready` is low exactly when `reg_wr`, `walk_start` or `walk_busy` is high. No event is consumed while it is low.
- R11: When `walk_start` is raised while idle, the readout sends N records. N is `DEPTH` in normal mode and TOS in call-stack mode, and N = 0 starts nothing. Record i comes from slot (T − i) mod `DEPTH`, where T is TOS in the start cycle. `rd_last` marks the final record, and the payload stays held while `rd_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Branch event valid |
| br_ready | output | 1 | Branch event accepted when high with valid |
| br_from | input | VA_W | Branch source address |
| br_to | input | VA_W | Branch destination address |
| br_class | input | 3 | Branch class code (R4) |
| br_ring0 | input | 1 | Target is privilege ring 0 |
| br_mispred | input | 1 | Branch was mispredicted |
| br_in_tx | input | 1 | Branch inside a transaction |
| br_abort | input | 1 | Branch is a transaction abort |
| rec_en | input | 1 | Recording enable |
| frz_on_pmi | input | 1 | Freeze on performance-monitor interrupt |
| pmi | input | 1 | Performance-monitor interrupt raised |
| frz_clr | input | 1 | Clear the freeze |
| frozen | output | 1 | Recording is frozen |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | IDX_W+2 | Register select and slot index |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data |
| walk_start | input | 1 | Start a newest-to-oldest readout |
| walk_busy | output | 1 | Readout in progress |
| rd_valid | output | 1 | Readout record valid |
| rd_ready | input | 1 | Readout consumer ready |
| rd_from | output | 64 | Readout source field |
| rd_to | output | 64 | Readout destination field |
| rd_last | output | 1 | Final record of the readout |

## Verification
A TOS that slips by one shows up on the next register read of TOS. It also changes which slot the next record lands in, so the fault reaches `reg_rdata` and the readout order within a few branches. A wrong freeze or filter decision changes TOS at the edge after the branch. The bench therefore keeps a reference model of all slots, TOS, select, freeze and the pending readout. It compares the handshake, register read data and readout stream on every clock, so a divergence is caught in the cycle it becomes visible.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

  localparam int SEL_W   = 10;
  localparam int CS_BIT  = 9;
  localparam int FLD_W   = 64;
  localparam int ADDR_TOP = 60;

  typedef enum logic [2:0] {
    BR_COND  = 3'd0,
    BR_RCALL = 3'd1,
    BR_ICALL = 3'd2,
    BR_RET   = 3'd3,
    BR_IJMP  = 3'd4,
    BR_RJMP  = 3'd5,
    BR_FAR   = 3'd6,
    BR_RSVD  = 3'd7
  } br_class_e;

  typedef enum logic [1:0] {
    RK_FROM = 2'd0,
    RK_TO   = 2'd1,
    RK_TOS  = 2'd2,
    RK_SEL  = 2'd3
  } reg_kind_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_PUSH = 2'd1,
    ACT_POP  = 2'd2
  } stack_act_e;

endpackage

// File: rtl/lbr_filter.sv
module lbr_filter
  import lbr_pkg::*;
#(
  parameter int VA_W = 48
) (
  input  logic             take,
  input  logic             gate,
  input  logic [SEL_W-1:0] sel,
  input  br_class_e        cls,
  input  logic             ring0,
  input  logic             mispred,
  input  logic             in_tx,
  input  logic             abort_f,
  input  logic [VA_W-1:0]  from_a,
  input  logic [VA_W-1:0]  to_a,
  output stack_act_e       act,
  output logic [FLD_W-1:0] from_fld,
  output logic [FLD_W-1:0] to_fld
);
  localparam int FROM_EXT = ADDR_TOP + 1 - VA_W;
  localparam int TO_EXT   = FLD_W - VA_W;

  logic priv_sup;
  logic class_sup;
  logic is_call;
  logic cs_mode;

  assign cs_mode  = sel[CS_BIT];
  assign priv_sup = ring0 ? sel[0] : sel[1];
  assign is_call  = (cls == BR_RCALL) || (cls == BR_ICALL);

  always_comb begin
    case (cls)
      BR_COND:  class_sup = sel[2];
      BR_RCALL: class_sup = sel[3];
      BR_ICALL: class_sup = sel[4];
      BR_RET:   class_sup = sel[5];
      BR_IJMP:  class_sup = sel[6];
      BR_RJMP:  class_sup = sel[7];
      BR_FAR:   class_sup = sel[8];
      default:  class_sup = 1'b1;
    endcase
  end

  always_comb begin
    act = ACT_NONE;
    if (take && gate && !priv_sup && !class_sup) begin
      if (!cs_mode)               act = ACT_PUSH;
      else if (is_call)           act = ACT_PUSH;
      else if (cls == BR_RET)     act = ACT_POP;
      else                        act = ACT_NONE;
    end
  end

  assign from_fld = {mispred, in_tx, abort_f, {FROM_EXT{from_a[VA_W-1]}}, from_a};
  assign to_fld   = {{TO_EXT{to_a[VA_W-1]}}, to_a};

endmodule

// File: rtl/lbr_ctrl.sv
module lbr_ctrl
  import lbr_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stack_act_e       act,
  input  logic             tos_we,
  input  logic [IDX_W-1:0] tos_wdata,
  input  logic             pmi,
  input  logic             frz_on_pmi,
  input  logic             cs_mode,
  input  logic             frz_clr,
  output logic [IDX_W-1:0] tos,
  output logic [IDX_W-1:0] push_slot,
  output logic             freeze_now,
  output logic             frozen
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  logic [IDX_W-1:0] tos_d;

  assign push_slot  = tos + ONE;
  assign freeze_now = pmi && frz_on_pmi && !cs_mode;

  always_comb begin
    tos_d = tos;
    if (tos_we)                tos_d = tos_wdata;
    else if (act == ACT_PUSH)  tos_d = push_slot;
    else if (act == ACT_POP)   tos_d = tos - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tos    <= '0;
      frozen <= 1'b0;
    end else begin
      tos    <= tos_d;
      frozen <= freeze_now || (frozen && !frz_clr);
    end
  end

  // R2: a push advances TOS by exactly one slot
  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_PUSH && !tos_we) |=> tos == IDX_W'($past(tos) + 1'b1));

  // R5: a pop retreats TOS by exactly one slot, wrapping at zero
  p_pop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_POP && !tos_we) |=> tos == IDX_W'($past(tos) - 1'b1));

  // R7: the freeze persists until cleared
  p_frozen_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !frz_clr) |=> frozen);

  // R8: call-stack mode never enters the freeze
  p_cs_no_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && cs_mode) |=> !frozen);

endmodule

// File: rtl/lbr_store.sv
module lbr_store
  import lbr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_we,
  input  logic [IDX_W-1:0] cap_idx,
  input  logic [FLD_W-1:0] cap_from,
  input  logic [FLD_W-1:0] cap_to,
  input  logic             sw_we_from,
  input  logic             sw_we_to,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic [FLD_W-1:0] sw_data,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [FLD_W-1:0] ra_from,
  output logic [FLD_W-1:0] ra_to,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [FLD_W-1:0] rb_from,
  output logic [FLD_W-1:0] rb_to
);
  logic [FLD_W-1:0] from_q [DEPTH];
  logic [FLD_W-1:0] to_q   [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit_sw;
    logic hit_cap;
    assign hit_sw  = (sw_idx  == IDX_W'(g));
    assign hit_cap = cap_we && (cap_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        from_q[g] <= '0;
        to_q[g]   <= '0;
      end else begin
        if (sw_we_from && hit_sw) from_q[g] <= sw_data;
        else if (hit_cap)         from_q[g] <= cap_from;
        if (sw_we_to && hit_sw)   to_q[g]   <= sw_data;
        else if (hit_cap)         to_q[g]   <= cap_to;
      end
    end
  end

  assign ra_from = from_q[ra_idx];
  assign ra_to   = to_q[ra_idx];
  assign rb_from = from_q[rb_idx];
  assign rb_to   = to_q[rb_idx];

endmodule

// File: rtl/lbr_walk.sv
module lbr_walk #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cs_mode,
  input  logic [IDX_W-1:0] tos,
  input  logic             rd_ready,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] n_start;
  logic [IDX_W-1:0] base;

  assign n_start = cs_mode ? {1'b0, tos} : FULL;
  assign idx     = base - cnt[IDX_W-1:0];
  assign last    = (cnt == total - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      total  <= '0;
      base   <= '0;
    end else if (!active) begin
      if (start && n_start != '0) begin
        active <= 1'b1;
        cnt    <= '0;
        total  <= n_start;
        base   <= tos;
      end
    end else if (rd_ready) begin
      if (last) active <= 1'b0;
      else      cnt    <= cnt + CNT_W'(1);
    end
  end

  // R11: a stalled record keeps its slot and stays valid
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !rd_ready) |=> (active && idx == $past(idx)));

  // R11: the walk ends right after its final record is taken
  p_last_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && last && rd_ready) |=> !active);

  // R11: the position never passes the record count
  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < total));

endmodule

// File: rtl/lbr_ring.sv
module lbr_ring
  import lbr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int VA_W  = 48,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  output logic              br_ready,
  input  logic [VA_W-1:0]   br_from,
  input  logic [VA_W-1:0]   br_to,
  input  logic [2:0]        br_class,
  input  logic              br_ring0,
  input  logic              br_mispred,
  input  logic              br_in_tx,
  input  logic              br_abort,
  input  logic              rec_en,
  input  logic              frz_on_pmi,
  input  logic              pmi,
  input  logic              frz_clr,
  output logic              frozen,
  input  logic              reg_wr,
  input  logic [IDX_W+1:0]  reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic              walk_start,
  output logic              walk_busy,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [63:0]       rd_from,
  output logic [63:0]       rd_to,
  output logic              rd_last
);
  reg_kind_e        kind;
  logic [IDX_W-1:0] ridx;
  logic [SEL_W-1:0] sel_q;
  logic [IDX_W-1:0] tos;
  logic [IDX_W-1:0] push_slot;
  logic [IDX_W-1:0] walk_idx;
  logic             freeze_now;
  logic             gate;
  logic             take;
  stack_act_e       act;
  logic [FLD_W-1:0] cap_from;
  logic [FLD_W-1:0] cap_to;
  logic [FLD_W-1:0] ra_from;
  logic [FLD_W-1:0] ra_to;

  assign kind     = reg_kind_e'(reg_addr[IDX_W +: 2]);
  assign ridx     = reg_addr[IDX_W-1:0];
  assign br_ready = !(reg_wr || walk_start || walk_busy);
  assign take     = br_valid && br_ready;
  assign gate     = rec_en && !frozen && !freeze_now;

  always_ff @(posedge clk) begin
    if (!rst_n)                        sel_q <= '0;
    else if (reg_wr && kind == RK_SEL) sel_q <= reg_wdata[SEL_W-1:0];
  end

  lbr_filter #(.VA_W(VA_W)) u_filter (
    .take     (take),
    .gate     (gate),
    .sel      (sel_q),
    .cls      (br_class_e'(br_class)),
    .ring0    (br_ring0),
    .mispred  (br_mispred),
    .in_tx    (br_in_tx),
    .abort_f  (br_abort),
    .from_a   (br_from),
    .to_a     (br_to),
    .act      (act),
    .from_fld (cap_from),
    .to_fld   (cap_to)
  );

  lbr_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .act        (act),
    .tos_we     (reg_wr && kind == RK_TOS),
    .tos_wdata  (reg_wdata[IDX_W-1:0]),
    .pmi        (pmi),
    .frz_on_pmi (frz_on_pmi),
    .cs_mode    (sel_q[CS_BIT]),
    .frz_clr    (frz_clr),
    .tos        (tos),
    .push_slot  (push_slot),
    .freeze_now (freeze_now),
    .frozen     (frozen)
  );

  lbr_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_we     (act == ACT_PUSH),
    .cap_idx    (push_slot),
    .cap_from   (cap_from),
    .cap_to     (cap_to),
    .sw_we_from (reg_wr && kind == RK_FROM),
    .sw_we_to   (reg_wr && kind == RK_TO),
    .sw_idx     (ridx),
    .sw_data    (reg_wdata),
    .ra_idx     (ridx),
    .ra_from    (ra_from),
    .ra_to      (ra_to),
    .rb_idx     (walk_idx),
    .rb_from    (rd_from),
    .rb_to      (rd_to)
  );

  lbr_walk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (walk_start),
    .cs_mode  (sel_q[CS_BIT]),
    .tos      (tos),
    .rd_ready (rd_ready),
    .active   (walk_busy),
    .idx      (walk_idx),
    .last     (rd_last)
  );

  assign rd_valid = walk_busy;

  always_comb begin
    case (kind)
      RK_FROM: reg_rdata = ra_from;
      RK_TO:   reg_rdata = ra_to;
      RK_TOS:  reg_rdata = {{(64-IDX_W){1'b0}}, tos};
      default: reg_rdata = {{(64-SEL_W){1'b0}}, sel_q};
    endcase
  end

  // R10: a blocked event leaves TOS untouched
  p_blocked_tos_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_ready && !(reg_wr && kind == RK_TOS)) |=> tos == $past(tos));

  // R9: a select write lands at the next edge
  p_sel_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && kind == RK_SEL) |=> sel_q == $past(reg_wdata[SEL_W-1:0]));

  // R6: with recording off, nothing is pushed or popped
  p_rec_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_en |-> act == ACT_NONE);

endmodule

// File: tb/lbr_ring_tb.sv
module lbr_ring_tb;
  localparam int DEPTH = 16;
  localparam int VA_W  = 48;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             br_valid = 0, br_ring0 = 0, br_mispred = 0, br_in_tx = 0, br_abort = 0;
  logic [VA_W-1:0]  br_from = '0, br_to = '0;
  logic [2:0]       br_class = '0;
  logic             rec_en = 0, frz_on_pmi = 0, pmi = 0, frz_clr = 0;
  logic             reg_wr = 0, walk_start = 0, rd_ready = 0;
  logic [IDX_W+1:0] reg_addr = '0;
  logic [63:0]      reg_wdata = '0;
  logic             br_ready, frozen, walk_busy, rd_valid, rd_last;
  logic [63:0]      reg_rdata, rd_from, rd_to;

  lbr_ring #(.DEPTH(DEPTH), .VA_W(VA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_ready(br_ready),
    .br_from(br_from), .br_to(br_to), .br_class(br_class), .br_ring0(br_ring0),
    .br_mispred(br_mispred), .br_in_tx(br_in_tx), .br_abort(br_abort),
    .rec_en(rec_en), .frz_on_pmi(frz_on_pmi), .pmi(pmi), .frz_clr(frz_clr),
    .frozen(frozen), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .walk_start(walk_start), .walk_busy(walk_busy),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_from(rd_from), .rd_to(rd_to),
    .rd_last(rd_last)
  );

  // reference model state
  logic [63:0] mf [DEPTH];
  logic [63:0] mt [DEPTH];
  int          mtos;
  logic [9:0]  msel;
  bit          mfrz;
  int          wq[$];
  int          wlen;

  int    n_chk = 0, n_bad = 0;
  bit    done = 0;
  string phase = "R1";

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (phase %s) actual=%h expected=%h", req, phase, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  function automatic logic [63:0] sx(logic [VA_W-1:0] a);
    return {{(64-VA_W){a[VA_W-1]}}, a};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin mf[i] = '0; mt[i] = '0; end
    mtos = 0; msel = '0; mfrz = 0; wq.delete(); wlen = 0;
  endtask

  task automatic compare();
    logic [63:0] exp_rd;
    int k, ix;
    k  = reg_addr[IDX_W+1:IDX_W];
    ix = reg_addr[IDX_W-1:0];
    case (k)
      0: exp_rd = mf[ix];
      1: exp_rd = mt[ix];
      2: exp_rd = 64'(mtos);
      default: exp_rd = 64'(msel);
    endcase
    chk("R10", 64'(br_ready), 64'(!(reg_wr || walk_start || wq.size() != 0)));
    chk("R7", 64'(frozen), 64'(mfrz));
    chk("R9", reg_rdata, exp_rd);
    chk("R11", 64'(walk_busy), 64'(wq.size() != 0));
    chk("R11", 64'(rd_valid), 64'(wq.size() != 0));
    if (wq.size() != 0) begin
      chk("R11", rd_from, mf[wq[0]]);
      chk("R11", rd_to, mt[wq[0]]);
      chk("R11", 64'(rd_last), 64'(wq.size() == 1));
    end
  endtask

  task automatic tick();
    bit busy, rdy, frz_now, gate, acc, sup;
    int act, cls;
    busy    = (wq.size() != 0);
    rdy     = !(reg_wr || walk_start || busy);
    frz_now = pmi && frz_on_pmi && !msel[9];
    gate    = rec_en && !mfrz && !frz_now;
    acc     = br_valid && rdy;
    cls     = br_class;
    sup     = (br_ring0 ? msel[0] : msel[1]) || (cls == 7) || (cls < 7 && msel[2 + cls]);
    act     = 0;
    if (acc && gate && !sup) begin
      if (!msel[9]) act = 1;
      else if (cls == 1 || cls == 2) act = 1;
      else if (cls == 3) act = 2;
    end
    @(posedge clk);
    if (!rst_n) model_reset();
    else begin
      if (busy && rd_ready) void'(wq.pop_front());
      else if (!busy && walk_start) begin
        wlen = msel[9] ? mtos : DEPTH;
        for (int i = 0; i < wlen; i++) wq.push_back((mtos - i + DEPTH) % DEPTH);
      end
      if (act == 1) begin
        mtos = (mtos + 1) % DEPTH;
        mf[mtos] = {br_mispred, br_in_tx, br_abort, sx(br_from)[60:0]};
        mt[mtos] = sx(br_to);
      end else if (act == 2) mtos = (mtos + DEPTH - 1) % DEPTH;
      if (reg_wr) begin
        case (int'(reg_addr[IDX_W+1:IDX_W]))
          0: mf[reg_addr[IDX_W-1:0]] = reg_wdata;
          1: mt[reg_addr[IDX_W-1:0]] = reg_wdata;
          2: mtos = int'(reg_wdata[IDX_W-1:0]);
          default: msel = reg_wdata[9:0];
        endcase
      end
      mfrz = frz_now || (mfrz && !frz_clr);
    end
    @(negedge clk);
    compare();
  endtask

  task automatic br(int cls, bit r0, logic [VA_W-1:0] f, logic [VA_W-1:0] t,
                    bit m, bit tx, bit ab);
    br_valid = 1; br_class = 3'(cls); br_ring0 = r0; br_from = f; br_to = t;
    br_mispred = m; br_in_tx = tx; br_abort = ab;
    tick();
    br_valid = 0;
  endtask

  task automatic wr(int kind, int idx, logic [63:0] d);
    reg_wr = 1; reg_addr = {2'(kind), IDX_W'(idx)}; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic peek(int kind, int idx);
    reg_addr = {2'(kind), IDX_W'(idx)};
    tick();
  endtask

  task automatic peek_all();
    peek(2, 0);
    for (int i = 0; i < DEPTH; i++) begin peek(0, i); peek(1, i); end
  endtask

  task automatic walk(bit stall);
    walk_start = 1; tick(); walk_start = 0;
    for (int n = 0; n < 4 * DEPTH && wq.size() != 0; n++) begin
      rd_ready = stall ? n[0] : 1'b1;
      tick();
    end
    rd_ready = 0;
    tick();
  endtask

  initial begin
    model_reset();
    // R1: reset state of slots, TOS, select and freeze
    phase = "R1";
    for (int i = 0; i < 3; i++) tick();
    rst_n = 1;
    tick();
    peek_all();
    peek(3, 0);
    // R2: normal capture with wrap past DEPTH and sign extension
    phase = "R2"; rec_en = 1;
    for (int i = 0; i < DEPTH + 5; i++)
      br(i % 7, i[0], {i[0], 47'(i * 4099 + 17)}, {~i[1], 47'(i * 733)}, i[1], i[2], i[0]);
    peek_all();
    // R3: privilege filtering
    phase = "R3";
    wr(3, 0, 64'h1);
    br(0, 1, 48'h1111, 48'h2222, 0, 0, 0);
    br(0, 0, 48'h3333, 48'h4444, 0, 0, 0);
    wr(3, 0, 64'h2);
    br(0, 0, 48'h5555, 48'h6666, 0, 0, 0);
    br(0, 1, 48'h7777, 48'h8888, 0, 0, 0);
    peek(2, 0);
    // R4: class filtering, each bit and the reserved code
    phase = "R4";
    for (int b = 0; b < 7; b++) begin
      wr(3, 0, 64'(1) << (b + 2));
      for (int c = 0; c < 8; c++) br(c, c[0], 48'(c + 100 * b + 1), 48'(c + 7), 0, 0, 0);
      peek(2, 0);
    end
    wr(3, 0, 64'h0);
    // R6: recording disabled
    phase = "R6"; rec_en = 0;
    br(1, 0, 48'hABC, 48'hDEF, 1, 1, 1);
    peek(2, 0);
    rec_en = 1;
    // R7: freeze on interrupt, same-cycle drop, clear, set-wins
    phase = "R7"; frz_on_pmi = 1;
    pmi = 1; br(0, 0, 48'h900, 48'h901, 0, 0, 0); pmi = 0;
    br(0, 0, 48'h902, 48'h903, 0, 0, 0);
    peek(2, 0);
    frz_clr = 1; pmi = 1; tick(); pmi = 0; tick(); frz_clr = 0;
    frz_clr = 1; tick(); frz_clr = 0;
    br(0, 0, 48'h904, 48'h905, 0, 0, 0);
    peek(2, 0);
    // R8: call-stack mode ignores the interrupt freeze
    phase = "R8";
    wr(3, 0, 64'h200);
    pmi = 1; tick(); pmi = 0; tick();
    // R5: call-stack push/pop and wrap below zero
    phase = "R5";
    wr(2, 0, 64'h1);
    br(3, 0, 48'h1, 48'h2, 0, 0, 0);
    br(3, 0, 48'h1, 48'h2, 0, 0, 0);
    peek(2, 0);
    wr(2, 0, 64'h0);
    br(1, 0, 48'hA0, 48'hA1, 0, 0, 0);
    br(2, 1, 48'hB0, 48'hB1, 1, 0, 0);
    br(4, 0, 48'hC0, 48'hC1, 0, 0, 0);
    br(1, 0, 48'hD0, 48'hD1, 0, 0, 0);
    br(3, 0, 48'hE0, 48'hE1, 0, 0, 0);
    peek(2, 0);
    // R11: call-stack readout of TOS records, then empty readout
    phase = "R11";
    walk(1);
    wr(2, 0, 64'h0);
    walk(0);
    wr(3, 0, 64'h0);
    walk(1);
    walk(0);
    // R10: events blocked during register writes and readouts
    phase = "R10";
    br_valid = 1; br_class = 0; br_from = 48'h77; br_to = 48'h78;
    reg_wr = 1; reg_addr = {2'd3, 4'd0}; reg_wdata = '0; tick(); reg_wr = 0;
    walk_start = 1; tick(); walk_start = 0;
    rd_ready = 0; tick(); tick();
    rd_ready = 1;
    for (int n = 0; n < DEPTH + 2; n++) tick();
    br_valid = 0; rd_ready = 0;
    peek(2, 0);
    // random mix of all features
    phase = "R9";
    for (int n = 0; n < 3000; n++) begin
      br_valid   = ($urandom % 3) != 0;
      br_class   = 3'($urandom);
      br_ring0   = $urandom;
      br_from    = {16'($urandom), 32'($urandom)};
      br_to      = {16'($urandom), 32'($urandom)};
      br_mispred = $urandom; br_in_tx = $urandom; br_abort = $urandom;
      rec_en     = ($urandom % 8) != 0;
      pmi        = ($urandom % 40) == 0;
      frz_clr    = ($urandom % 10) == 0;
      frz_on_pmi = $urandom;
      walk_start = ($urandom % 60) == 0;
      rd_ready   = $urandom;
      reg_addr   = 6'($urandom);
      reg_wr     = ($urandom % 12) == 0;
      reg_wdata  = {32'($urandom), 32'($urandom)};
      if (reg_wr && reg_addr[5:4] == 2'd3) reg_wdata = 64'($urandom % 1024);
      tick();
    end
    br_valid = 0; reg_wr = 0; walk_start = 0; pmi = 0;
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule